// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Condition Word

The unit adds or subtracts two 16-bit operands, or shifts the first operand by one place, and writes the outcome to a result register. Alongside the result it keeps a packed 16-bit condition word. This word holds the carry, zero and sign of the last add/subtract and four overflow/underflow flags. It also holds the bit lost by the last shift, the current 2-bit arithmetic mode and an operation-done bit that software polls.

The mode picks how an add/subtract result that does not fit is stored. Modes 00 and 10 keep the low 16 bits, so the value wraps. Mode 01 treats operands as two's complement and clamps to 8000h/7FFFh. Mode 11 treats them as unsigned and clamps to 0000h/FFFFh. The mode is written through a dedicated write port and is latched together with the operands when an operation starts.

Top module: `sat_alu`

## Requirements
- R1: After reset the result reads 0000h and the condition word reads 0001h: done set, mode 00, all other flags clear.
- R2: A start seen while done (bit 0) is 1 is accepted. Done reads 0 after that clock edge. On the following edge the result and flags are written and done returns to 1.
- R3: A start seen while done is 0 is ignored. The pending operation completes with its own operands.
- R4: In modes 00 and 10 the result is the low 16 bits of the true sum or difference.
- R5: In mode 01 the operands are signed. A true result above 32767 stores 7FFFh and one below -32768 stores 8000h.
- R6: In mode 11 the operands are unsigned. A true result above 65535 stores FFFFh and one below 0 stores 0000h.
- R7: Every add/subtract sets bit 1 when the signed true result exceeds 32767, bit 2 when it is below -32768, bit 3 when the unsigned true result exceeds 65535 and bit 4 when it is below 0. These flags are the same in every mode.
- R8: Bit 13 (carry) is the carry out of an add, or the borrow of a subtract (set when the first operand is below the second as unsigned).
- R9: Bit 6 is set when the stored add/subtract result is 0000h. Bit 5 copies bit 15 of the stored result.
- R10: Opcode 10 shifts operand A left by one and opcode 11 shifts it right by one with zero fill. Bit 15 of the condition word takes the bit shifted out. Bits 13 and 6:1 keep their values.
- R11: A mode write stores its 2-bit value in condition bits 12:11. An operation uses the mode held when it was accepted, even if a write lands on the same edge. Bits 14 and 10:7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an operation |
| op_i | input | 2 | 00 add, 01 subtract, 10 shift left, 11 shift right |
| opa_i | input | 16 | Operand A |
| opb_i | input | 16 | Operand B (add/subtract only) |
| mode_we_i | input | 1 | Write enable for the mode field |
| mode_wdata_i | input | 2 | New mode value |
| result_o | output | 16 | Result register |
| status_o | output | 16 | Condition word |

## Verification
A start driven before edge k is accepted at k, so the done bit is sampled low half a cycle after k. Result and condition word are written at edge k+1 and are sampled half a cycle after that. A mode write lands at its own edge and is read back half a cycle later. Second starts during the busy cycle are driven before edge k+1 and judged from the value written at k+1. Each operation therefore takes exactly two sampled clock cycles, and the bench never polls done.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
  localparam int DATA_W = 16;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_SHL = 2'b10,
    OP_SHR = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              carry;
    logic              s_ovf;
    logic              s_und;
    logic              u_ovf;
    logic              u_und;
  } addsub_t;

  typedef struct packed {
    logic              out_bit;
    logic [DATA_W-1:0] res;
  } shift_t;

  // Add or subtract, with flags from the unclamped result and mode-dependent store value
  function automatic addsub_t f_addsub(input logic [DATA_W-1:0] a,
                                       input logic [DATA_W-1:0] b,
                                       input logic sub,
                                       input logic [MODE_W-1:0] mode);
    addsub_t     r;
    logic [DATA_W:0] u;
    logic [DATA_W:0] s;
    logic [DATA_W:0] ua;
    logic [DATA_W:0] ub;
    logic [DATA_W:0] sa;
    logic [DATA_W:0] sb;
    ua = {1'b0, a};
    ub = {1'b0, b};
    sa = {a[DATA_W-1], a};
    sb = {b[DATA_W-1], b};
    u  = sub ? (ua - ub) : (ua + ub);
    s  = sub ? (sa - sb) : (sa + sb);
    r.u_ovf = ~sub & u[DATA_W];
    r.u_und = sub & u[DATA_W];
    r.carry = u[DATA_W];
    r.s_ovf = ~s[DATA_W] & s[DATA_W-1];
    r.s_und = s[DATA_W] & ~s[DATA_W-1];
    r.res   = u[DATA_W-1:0];
    if (mode == 2'b01) begin
      if (r.s_ovf)      r.res = {1'b0, {(DATA_W-1){1'b1}}};
      else if (r.s_und) r.res = {1'b1, {(DATA_W-1){1'b0}}};
    end else if (mode == 2'b11) begin
      if (r.u_ovf)      r.res = {DATA_W{1'b1}};
      else if (r.u_und) r.res = '0;
    end
    return r;
  endfunction

  function automatic shift_t f_shift(input logic [DATA_W-1:0] a, input logic left);
    shift_t r;
    if (left) begin
      r.out_bit = a[DATA_W-1];
      r.res     = {a[DATA_W-2:0], 1'b0};
    end else begin
      r.out_bit = a[0];
      r.res     = {1'b0, a[DATA_W-1:1]};
    end
    return r;
  endfunction
endpackage

// File: rtl/sat_alu_ctrl.sv
module sat_alu_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic wb_fire_o,
  output logic done_o
);
  logic done_q;

  assign accept_o  = start_i & done_q;
  assign wb_fire_o = ~done_q;
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b1;
    else if (accept_o) done_q <= 1'b0;
    else if (!done_q)  done_q <= 1'b1;
  end
endmodule

// File: rtl/sat_alu_exec.sv
module sat_alu_exec
  import sat_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              is_addsub_o,
  output addsub_t           as_o,
  output shift_t            sh_o
);
  assign is_addsub_o = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign as_o        = f_addsub(a_i, b_i, op_i == OP_SUB, mode_i);
  assign sh_o        = f_shift(a_i, op_i == OP_SHL);
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [1:0]  op_i,
  input  logic [15:0] opa_i,
  input  logic [15:0] opb_i,
  input  logic        mode_we_i,
  input  logic [1:0]  mode_wdata_i,
  output logic [15:0] result_o,
  output logic [15:0] status_o
);
  // named internal events for the checker
  logic              accept;
  logic              wb_fire;
  logic              wb_addsub;
  logic              done;
  logic [MODE_W-1:0] stage_mode;

  logic [DATA_W-1:0] stage_a, stage_b;
  alu_op_e           stage_op;
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] result_q;
  logic              shout_q, carry_q, zero_q, sign_q;
  logic              s_ovf_q, s_und_q, u_ovf_q, u_und_q;
  logic              is_addsub;
  addsub_t           as_r;
  shift_t            sh_r;

  sat_alu_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .accept_o  (accept),
    .wb_fire_o (wb_fire),
    .done_o    (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_a    <= '0;
      stage_b    <= '0;
      stage_op   <= OP_ADD;
      stage_mode <= '0;
    end else if (accept) begin
      stage_a    <= opa_i;
      stage_b    <= opb_i;
      stage_op   <= alu_op_e'(op_i);
      stage_mode <= mode_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_wdata_i;
  end

  sat_alu_exec u_exec (
    .a_i         (stage_a),
    .b_i         (stage_b),
    .op_i        (stage_op),
    .mode_i      (stage_mode),
    .is_addsub_o (is_addsub),
    .as_o        (as_r),
    .sh_o        (sh_r)
  );

  assign wb_addsub = wb_fire & is_addsub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      shout_q  <= 1'b0;
      carry_q  <= 1'b0;
      zero_q   <= 1'b0;
      sign_q   <= 1'b0;
      s_ovf_q  <= 1'b0;
      s_und_q  <= 1'b0;
      u_ovf_q  <= 1'b0;
      u_und_q  <= 1'b0;
    end else if (wb_fire) begin
      if (is_addsub) begin
        result_q <= as_r.res;
        carry_q  <= as_r.carry;
        zero_q   <= (as_r.res == '0);
        sign_q   <= as_r.res[DATA_W-1];
        s_ovf_q  <= as_r.s_ovf;
        s_und_q  <= as_r.s_und;
        u_ovf_q  <= as_r.u_ovf;
        u_und_q  <= as_r.u_und;
      end else begin
        result_q <= sh_r.res;
        shout_q  <= sh_r.out_bit;
      end
    end
  end

  assign result_o = result_q;
  assign status_o = {shout_q, 1'b0, carry_q, mode_q, 4'b0000,
                     zero_q, sign_q, u_und_q, u_ovf_q, s_und_q, s_ovf_q, done};
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        wb_fire,
  input logic        wb_addsub,
  input logic [1:0]  stage_mode,
  input logic [15:0] result_o,
  input logic [15:0] status_o
);
  a_r2_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !status_o[0]);

  a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[0] |=> status_o[0]);

  a_r3_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[0] |-> !accept);

  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_fire |=> $stable(result_o));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_o[4:3]) && $onehot0(status_o[2:1]));

  a_r5_signed_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_addsub && stage_mode == 2'b01) |=>
      ((!status_o[1] || result_o == 16'h7FFF) && (!status_o[2] || result_o == 16'h8000)));

  a_r6_unsigned_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_addsub && stage_mode == 2'b11) |=>
      ((!status_o[3] || result_o == 16'hFFFF) && (!status_o[4] || result_o == 16'h0000)));

  a_r9_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    wb_addsub |=> (status_o[6] == (result_o == 16'h0000)) && (status_o[5] == result_o[15]));
endmodule

bind sat_alu sat_alu_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .wb_fire    (wb_fire),
  .wb_addsub  (wb_addsub),
  .stage_mode (stage_mode),
  .result_o   (result_o),
  .status_o   (status_o)
);

// File: tb/sat_alu_bench.sv
module sat_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [15:0] opa_i = '0;
  logic [15:0] opb_i = '0;
  logic        mode_we_i = 1'b0;
  logic [1:0]  mode_wdata_i = '0;
  logic [15:0] result_o;
  logic [15:0] status_o;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model of the condition word
  logic       m_shout = 0, m_carry = 0, m_zero = 0, m_sign = 0;
  logic [3:0] m_flags = '0;   // {u_und, u_ovf, s_und, s_ovf}
  logic [1:0] m_mode = '0;

  logic [15:0] vals [12] = '{16'h0000, 16'h0001, 16'h0002, 16'h4000, 16'h7FFE, 16'h7FFF,
                             16'h8000, 16'h8001, 16'hABCD, 16'hFFFE, 16'hFFFF, 16'h1234};

  always #10 clk = ~clk;  // 50 MHz

  sat_alu u_sat_alu (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .mode_we_i(mode_we_i),
    .mode_wdata_i(mode_wdata_i), .result_o(result_o), .status_o(status_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_status();
    return {m_shout, 1'b0, m_carry, m_mode, 4'b0000, m_zero, m_sign, m_flags, 1'b1};
  endfunction

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_we_i = 1'b1; mode_wdata_i = m;
    @(negedge clk);
    mode_we_i = 1'b0;
    m_mode = m;
    chk("R11 mode field", {14'b0, status_o[12:11]}, {14'b0, m});
  endtask

  // one operation; optional same-edge mode write and a busy-cycle start poke
  task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                        input bit wr_mode, input logic [1:0] new_mode, input bit poke);
    int ua, ub, sa, sb, tu, ts;
    logic [15:0] exp_r;
    logic [1:0]  used_mode;
    string       tag;
    used_mode = m_mode;
    ua = int'(a); ub = int'(b);
    sa = a[15] ? ua - 65536 : ua;
    sb = b[15] ? ub - 65536 : ub;
    if (op == 2'b00 || op == 2'b01) begin
      tu = (op == 2'b00) ? ua + ub : ua - ub;
      ts = (op == 2'b00) ? sa + sb : sa - sb;
      m_flags = {tu < 0, tu > 65535, ts < -32768, ts > 32767};
      m_carry = (tu < 0) || (tu > 65535);
      exp_r = 16'(tu & 32'hFFFF);
      if (used_mode == 2'b01) begin
        if (ts > 32767) exp_r = 16'h7FFF;
        else if (ts < -32768) exp_r = 16'h8000;
        tag = "R5 signed clamp";
      end else if (used_mode == 2'b11) begin
        if (tu > 65535) exp_r = 16'hFFFF;
        else if (tu < 0) exp_r = 16'h0000;
        tag = "R6 unsigned clamp";
      end else tag = "R4 wrap";
      m_zero = (exp_r == 16'h0000);
      m_sign = exp_r[15];
    end else begin
      if (op == 2'b10) begin exp_r = 16'((ua * 2) & 32'hFFFF); m_shout = a[15]; end
      else begin exp_r = 16'(ua / 2); m_shout = a[0]; end
      tag = "R10 shift";
    end
    @(negedge clk);
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    if (wr_mode) begin mode_we_i = 1'b1; mode_wdata_i = new_mode; end
    @(negedge clk);
    mode_we_i = 1'b0;
    if (wr_mode) m_mode = new_mode;
    chk("R2 done low after accept", {15'b0, status_o[0]}, 16'h0000);
    if (poke) begin
      start_i = 1'b1; op_i = ~op; opa_i = ~a; opb_i = ~b;
    end else start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) chk("R3 busy start ignored", result_o, exp_r);
    else      chk(tag, result_o, exp_r);
    chk("R2 R7 R8 R9 R10 R11 status", status_o, model_status());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset result", result_o, 16'h0000);
    chk("R1 reset status", status_o, 16'h0001);

    // sweep all modes, both arithmetic opcodes, all operand pairs (R4 R5 R6 R7 R8 R9)
    for (int m = 0; m < 4; m++) begin
      set_mode(2'(m));
      for (int op = 0; op < 2; op++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 12; j++)
            run_op(2'(op), vals[i], vals[j], 1'b0, 2'b00, 1'b0);
    end

    // shifts leave add/sub flags untouched (R10)
    set_mode(2'b01);
    run_op(2'b00, 16'h7FFF, 16'h0001, 1'b0, 2'b00, 1'b0);
    for (int i = 0; i < 12; i++) begin
      run_op(2'b10, vals[i], 16'h0000, 1'b0, 2'b00, 1'b0);
      run_op(2'b11, vals[i], 16'h0000, 1'b0, 2'b00, 1'b0);
    end

    // busy-cycle start ignored (R3)
    run_op(2'b00, 16'h1234, 16'h0101, 1'b0, 2'b00, 1'b1);
    run_op(2'b01, 16'h0000, 16'h0001, 1'b0, 2'b00, 1'b1);

    // mode write on the accept edge: operation keeps old mode (R11)
    run_op(2'b00, 16'h7FFF, 16'h0001, 1'b1, 2'b11, 1'b0);
    run_op(2'b00, 16'h7FFF, 16'h0001, 1'b1, 2'b01, 1'b0);
    run_op(2'b01, 16'h0000, 16'h0001, 1'b1, 2'b10, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule